// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Parity

This block sends bytes over an asynchronous serial line. Each frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and a high stop bit. An external bit-period tick sets the pace. Every bit lasts exactly one interval between ticks, and the first bit of a frame begins on a tick.

A two-bit parity select chooses one of four framings:

| Select | Framing |
|--------|---------|
| `00` | No parity bit |
| `01` | A parity bit that is always 0 |
| `10` | Odd parity |
| `11` | Even parity |

The select is captured only while transmission is not active. Software therefore sets the framing before it raises the transmit enable, and any change made afterwards has no effect.

Two enables control the block. A unit enable gates the transmit enable: a write strobe starts a frame only while both are high and the block is idle. After the stop bit ends, the block gives a one-cycle completion pulse. A busy flag covers the frame from the accepted strobe to that pulse.

The controller is a single state machine with these states:

| State | What happens |
|-------|--------------|
| IDLE | Line high. Waiting for a strobe. |
| ARM | Strobe accepted. Line still high while the block waits for the next tick. |
| START | Low start bit. |
| DATA | Eight data bits, shifted out. |
| PARITY | Parity bit. |
| STOP | High stop bit. |
| DONE | One cycle with the completion pulse. |

Its transitions are:

- IDLE→ARM on a strobe while enabled.
- ARM→START on a tick.
- START→DATA on a tick.
- DATA→DATA on a tick until the last data bit has been sent.
- DATA→PARITY on a tick after the last data bit, if the framing has a parity bit.
- DATA→STOP on a tick after the last data bit, if the framing has no parity bit.
- PARITY→STOP on a tick.
- STOP→DONE on a tick.
- DONE→IDLE unconditionally.

Top module: `ser_tx`

## Requirements
- R1: After reset the serial line is high, busy is low, done is low and the captured parity select is `00` (no parity).
- R2: A frame is a 0 start bit, then data bits 0 through 7 in that order, then the optional parity bit, then a 1 stop bit. The line changes only in the cycle after a tick, so each bit lasts exactly one tick interval.
- R3: With select `00` the frame has no parity bit and is ten bits long.
- R4: With select `01` the frame carries a parity bit of 0 whatever the data.
- R5: With select `10` the parity bit makes the total count of 1s over the data and parity bits odd.
- R6: With select `11` the parity bit makes the total count of 1s over the data and parity bits even.
- R7: The parity select is captured only in cycles where unit enable and transmit enable are not both high. A change while both are high has no effect on later frames.
- R8: A write strobe starts a frame only when unit enable and transmit enable are both high and the block is idle. Otherwise busy stays low and the line stays high.
- R9: Busy rises in the cycle after an accepted strobe and stays high until the done cycle ends. A strobe during a frame is ignored and does not change the bytes sent.
- R10: Done is high for exactly one cycle, in the cycle right after the stop bit's tick interval ends, with the line high.
- R11: After an accepted strobe the line stays high until the next tick, and the start bit begins in the cycle after that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Unit enable; gates the transmit enable |
| tx_en | input | 1 | Transmit enable |
| par_sel | input | 2 | Parity select: 00 none, 01 zero, 10 odd, 11 even |
| wr_stb | input | 1 | One-cycle write strobe for `wr_data` |
| wr_data | input | 8 | Byte to send |
| bit_tick | input | 1 | One-cycle pulse once per bit period |
| txd | output | 1 | Serial line; idles high |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse after the stop bit ends |

## Verification
Frames are sent in all four parity modes. The bytes are chosen so that each mode is told apart from the others:

- 0x00 and 0x01 flip the odd parity bit.
- 0x03 and 0x07 flip the even parity bit.
- 0xFF shows that the zero mode ignores the data.
- 0xA5 shows bit order and the ten-bit framing.

The parity select is then changed while the transmitter is enabled, and the next frame is checked to keep the old even framing. The chosen byte would carry a different parity bit under the new framing, so the check can see the difference. A second strobe during a running frame, and strobes given while either enable is low, must leave the line and the expected frame sequence untouched.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_DONE
    } tx_state_e;

endpackage

// File: rtl/ser_tx_cfg.sv
module ser_tx_cfg
    import ser_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open_i,
    input  logic [1:0] sel_i,
    output par_mode_e  mode_o
);

    // The select passes through only while transmission is not active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= PAR_NONE;
        end else if (open_i) begin
            mode_o <= par_mode_e'(sel_i);
        end
    end

endmodule

// File: rtl/ser_tx_parity.sv
module ser_tx_parity
    import ser_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  par_mode_e              mode_i,
    input  logic [DATA_BITS-1:0]   data_i,
    output logic                   bit_o,
    output logic                   present_o
);

    logic ones_odd;

    assign ones_odd = ^data_i;

    always_comb begin
        unique case (mode_i)
            PAR_NONE: begin
                bit_o     = 1'b0;
                present_o = 1'b0;
            end
            PAR_ZERO: begin
                bit_o     = 1'b0;
                present_o = 1'b1;
            end
            PAR_ODD: begin
                bit_o     = ~ones_odd;
                present_o = 1'b1;
            end
            PAR_EVEN: begin
                bit_o     = ones_odd;
                present_o = 1'b1;
            end
            default: begin
                bit_o     = 1'b0;
                present_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ser_tx_fsm.sv
module ser_tx_fsm
    import ser_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic                 wr_stb_i,
    input  logic [DATA_BITS-1:0] wr_data_i,
    input  logic                 tick_i,
    input  logic                 par_bit_i,
    input  logic                 par_present_i,
    output logic                 txd_o,
    output logic                 busy_o,
    output logic                 done_o
);

    localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_BITS - 1);

    tx_state_e              state_q;
    tx_state_e              state_d;
    logic [DATA_BITS-1:0]   shreg_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   par_q;
    logic                   has_par_q;
    logic                   accept;

    assign accept = (state_q == ST_IDLE) && wr_stb_i && go_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame datapath: byte, bit index and parity are fixed at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            cnt_q     <= '0;
            par_q     <= 1'b0;
            has_par_q <= 1'b0;
        end else if (accept) begin
            shreg_q   <= wr_data_i;
            cnt_q     <= '0;
            par_q     <= par_bit_i;
            has_par_q <= par_present_i;
        end else if (state_q == ST_DATA && tick_i) begin
            shreg_q <= shreg_q >> 1;
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (tick_i) state_d = ST_START;
            end
            ST_START: begin
                if (tick_i) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (tick_i && cnt_q == LAST_IDX) begin
                    state_d = has_par_q ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (tick_i) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (tick_i) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        txd_o  = 1'b1;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_ARM: begin
                txd_o = 1'b1;
            end
            ST_START: begin
                txd_o = 1'b0;
            end
            ST_DATA: begin
                txd_o = shreg_q[0];
            end
            ST_PARITY: begin
                txd_o = par_q;
            end
            ST_STOP: begin
                txd_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 unit_en,
    input  logic                 tx_en,
    input  logic [1:0]           par_sel,
    input  logic                 wr_stb,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 bit_tick,
    output logic                 txd,
    output logic                 busy,
    output logic                 done
);

    logic      tx_active;
    par_mode_e mode_q;
    logic      par_bit;
    logic      par_present;

    assign tx_active = unit_en & tx_en;

    ser_tx_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (~tx_active),
        .sel_i  (par_sel),
        .mode_o (mode_q)
    );

    ser_tx_parity #(.DATA_BITS(DATA_BITS)) u_par (
        .mode_i    (mode_q),
        .data_i    (wr_data),
        .bit_o     (par_bit),
        .present_o (par_present)
    );

    ser_tx_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_i          (tx_active),
        .wr_stb_i      (wr_stb),
        .wr_data_i     (wr_data),
        .tick_i        (bit_tick),
        .par_bit_i     (par_bit),
        .par_present_i (par_present),
        .txd_o         (txd),
        .busy_o        (busy),
        .done_o        (done)
    );

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       unit_en,
    input logic       tx_en,
    input logic       wr_stb,
    input logic       bit_tick,
    input logic       txd,
    input logic       busy,
    input logic       done,
    input logic [1:0] mode_q
);

    // R2
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(txd));

    // R7
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && tx_en && $past(unit_en && tx_en)) |-> $stable(mode_q));

    // R8
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(unit_en && tx_en)) |=> !busy);

    // R9
    busy_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_stb && unit_en && tx_en));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (txd && busy));

    // R11
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(bit_tick));

endmodule

bind ser_tx ser_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_en  (unit_en),
    .tx_en    (tx_en),
    .wr_stb   (wr_stb),
    .bit_tick (bit_tick),
    .txd      (txd),
    .busy     (busy),
    .done     (done),
    .mode_q   (mode_q)
);

// File: tb/ser_tx_test.sv
module ser_tx_test;

    localparam int P = 8;

    typedef struct {
        logic [10:0] bits;
        int          len;
        string       tag;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unit_en = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick;
    logic       txd;
    logic       busy;
    logic       done;

    logic [2:0] tcnt = 3'd0;
    logic [1:0] model_mode = 2'b00;
    frame_t     exp_q[$];
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) tcnt <= tcnt + 3'd1;
    assign bit_tick = (tcnt == 3'(P - 1));

    ser_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .unit_en  (unit_en),
        .tx_en    (tx_en),
        .par_sel  (par_sel),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .bit_tick (bit_tick),
        .txd      (txd),
        .busy     (busy),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic frame_t build(input logic [7:0] d, input logic [1:0] m);
        frame_t f;
        int ones = 0;
        logic pb;
        for (int i = 0; i < 8; i++) ones += d[i];
        case (m)
            2'b01: pb = 1'b0;
            2'b10: pb = (ones % 2 == 0);
            2'b11: pb = (ones % 2 == 1);
            default: pb = 1'b0;
        endcase
        f.bits = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) f.bits[i+1] = d[i];
        if (m == 2'b00) begin
            f.len = 10;
            f.tag = "R3";
        end else begin
            f.bits[9] = pb;
            f.len = 11;
            f.tag = (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R6";
        end
        return f;
    endfunction

    task automatic set_en(input logic u, input logic t);
        @(negedge clk);
        unit_en = u;
        tx_en = t;
        if (!(u && t)) model_mode = par_sel;
    endtask

    task automatic set_sel(input logic [1:0] v);
        @(negedge clk);
        par_sel = v;
        if (!(unit_en && tx_en)) model_mode = v;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Driver: push the expected frame, strobe, and check the line holds high in ARM
    task automatic start_frame(input logic [7:0] d);
        wait_idle();
        exp_q.push_back(build(d, model_mode));
        wr_data = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        // R11: strobe accepted, line still high until the next tick
        check(busy && txd, "R11", {busy, txd}, 2'b11);
    endtask

    task automatic send(input logic [7:0] d);
        start_frame(d);
        wait_idle();
    endtask

    // Monitor: capture each frame on the line and compare with the queue
    initial begin
        frame_t f;
        logic [10:0] got;
        int ndone;
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                got = '1;
                repeat (P / 2) @(negedge clk);
                got[0] = txd;
                if (exp_q.size() == 0) begin
                    check(0, "R8", 1, 0);
                    f.len = 11;
                    f.bits = '1;
                    f.tag = "R8";
                end else begin
                    f = exp_q.pop_front();
                end
                for (int i = 1; i < f.len; i++) begin
                    repeat (P) @(negedge clk);
                    got[i] = txd;
                end
                // R2: start, data LSB first, parity, stop
                check(got == f.bits, f.tag, int'(got), int'(f.bits));
                ndone = 0;
                for (int i = 0; i < P; i++) begin
                    @(negedge clk);
                    if (done) ndone++;
                end
                // R10: exactly one done cycle after the stop bit
                check(ndone == 1, "R10", ndone, 1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(txd == 1'b1, "R1", txd, 1);
        check(busy == 1'b0, "R1", busy, 0);
        check(done == 1'b0, "R1", done, 0);
        rst_n = 1'b1;

        // R3 with R2: no parity, bit order shown by 0xA5
        set_en(1'b1, 1'b0);
        set_sel(2'b00);
        set_en(1'b1, 1'b1);
        send(8'hA5);

        // R4: zero parity on all-ones data
        set_en(1'b1, 1'b0);
        set_sel(2'b01);
        set_en(1'b1, 1'b1);
        send(8'hFF);

        // R5: odd parity
        set_en(1'b1, 1'b0);
        set_sel(2'b10);
        set_en(1'b1, 1'b1);
        send(8'h00);
        send(8'h01);

        // R6: even parity
        set_en(1'b1, 1'b0);
        set_sel(2'b11);
        set_en(1'b1, 1'b1);
        send(8'h03);
        send(8'h07);

        // R7: select changed while enabled has no effect; even parity of 0x01 is 1
        set_sel(2'b10);
        send(8'h01);

        // R8: strobe ignored with unit enable low
        set_en(1'b0, 1'b1);
        @(negedge clk);
        wr_data = 8'h55;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (3 * P) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R8", {busy, txd}, 2'b01);

        // R8: strobe ignored with transmit enable low
        set_en(1'b1, 1'b0);
        @(negedge clk);
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (3 * P) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R8", {busy, txd}, 2'b01);

        // R9: second strobe mid-frame is ignored (mode now odd from par_sel)
        set_en(1'b1, 1'b1);
        start_frame(8'h3C);
        repeat (3 * P) @(negedge clk);
        wr_data = 8'hC3;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check(busy == 1'b1, "R9", busy, 1);
        wait_idle();
        repeat (3 * P) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R9", {busy, txd}, 2'b01);

        repeat (2 * P) @(negedge clk);
        // R2: every expected frame has been seen on the line
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        summary();
    end

endmodule